// File: doc/BRIEF.md
# Illegal-Condition Trap Detector

This block sits next to a small 8-bit controller core and turns two classes of runaway behaviour into one observable event. It owns the subroutine stack pointer, a byte pointer into segment 0 of data RAM that moves down on every call, interrupt entry or push and up on every return or pop. It holds the populated stack bytes itself. For any unpopulated address it supplies a fill value: all ones for data RAM and all zeros for program memory.

The fill values are what make the scheme work. A zero byte is the software-interrupt opcode. A program that runs off into unpopulated program memory therefore fetches that opcode straight away. A program that returns more often than it called pops two all-ones bytes. The result is a return address at the top of the 15-bit program space, and the next fetch there again reads zero. Either way the fetch guard raises a sticky software-interrupt pending flag. Recovery code clears the flag with a dedicated strobe and may reload the stack pointer.

Same-cycle requests are resolved by a fixed priority: pointer load first, then call or interrupt entry, then return, then push/pop. A push and a pop in the same cycle pass the pushed byte straight to the pop output.

Top module: `illegal_trap_unit`

## Requirements
- R1: Reset sets the stack pointer to 0x6F and clears the pending flag, the return-address output, the pop-data output and every stored stack byte.
- R2: A call or interrupt entry stores the low byte of `link_pc_i` at offset SP and the byte `link_pc_i >> 8` at offset SP-1, then lowers SP by 2.
- R3: A push stores `push_data_i` at SP and lowers SP by 1. A pop loads `pop_data_o` with the byte at SP+1 and raises SP by 1. Push and pop together leave SP unchanged, store nothing, and put `push_data_i` on `pop_data_o`.
- R4: A return raises SP by 2 and, one edge later, drives `ret_addr_o` = {byte at SP+1, byte at SP+2}, truncated to 15 bits.
- R5: A data read address is {segment[9:8], offset[7:0]}. Only segment 0 with offset 0x00–0x6F is populated. Every other read returns 0xFF, and stack writes to unpopulated offsets are dropped. SP arithmetic wraps modulo 256.
- R6: `fetch_data_o` equals `rom_data_i` when `fetch_addr_i` <= 0xFFF, and 0x00 otherwise.
- R7: A fetch strobe whose `fetch_data_o` is 0x00 sets the pending flag at the next edge. The flag then holds until `clr_pend_i`, and a set in the same cycle as a clear wins.
- R8: A pointer load writes `sp_load_val_i` into SP and cancels every other stack request of that cycle, including its stores and output updates.
- R9: Among stack requests in one cycle, call/interrupt beats return, and return beats push/pop.
- R10: `underflow_o` is high exactly when SP is above 0x6F.
- R11: A return executed with SP at 0x6F yields return address 0x7FFF. A fetch at that address reads 0x00 and sets the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Subroutine call strobe |
| irq_i | input | 1 | Interrupt entry strobe |
| ret_i | input | 1 | Return strobe |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| link_pc_i | input | 15 | Return address saved by a call or interrupt entry |
| push_data_i | input | 8 | Byte saved by a push |
| sp_load_i | input | 1 | Stack pointer load strobe |
| sp_load_val_i | input | 8 | Value for a stack pointer load |
| ram_rd_addr_i | input | 10 | Data RAM read address {segment, offset} |
| ram_rd_data_o | output | 8 | Data RAM read data, 0xFF when unpopulated |
| fetch_i | input | 1 | Instruction fetch strobe |
| fetch_addr_i | input | 15 | Instruction fetch address |
| rom_data_i | input | 8 | Raw byte from program memory |
| fetch_data_o | output | 8 | Fetched byte, 0x00 when unpopulated |
| clr_pend_i | input | 1 | Clears the software-interrupt pending flag |
| sp_o | output | 8 | Current stack pointer |
| ret_addr_o | output | 15 | Address popped by the last return |
| pop_data_o | output | 8 | Byte delivered by the last pop |
| swi_pend_o | output | 1 | Software-interrupt pending flag |
| underflow_o | output | 1 | SP above the top populated stack byte |

## Verification
The stack is driven by a random mix of calls, interrupt entries, returns, pushes, pops, push/pop pairs, stacked conflicting requests and occasional pointer loads. Comparing SP and the popped values separates correct ordering of the two return-address bytes from swapped ordering, and correct priority from a merged net-delta scheme. Fetches are spread over the populated region, the first unpopulated address, the top of the address space and zero-valued ROM bytes, so that the fill mux and the pending-flag trigger can be told apart. Directed runs cover the over-return path to 0x7FFF and a set in the same cycle as a clear.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;

  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Resolved stack request for one cycle
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_LOAD,
    OP_LINK,
    OP_UNLINK,
    OP_PUSH,
    OP_POP,
    OP_SWAP
  } stk_op_e;

  // Fixed priority: load > link > unlink > push/pop
  function automatic stk_op_e decode_op(logic ld, logic link, logic unlink,
                                        logic push, logic pop);
    if (ld)               return OP_LOAD;
    if (link)             return OP_LINK;
    if (unlink)           return OP_UNLINK;
    if (push && pop)      return OP_SWAP;
    if (push)             return OP_PUSH;
    if (pop)              return OP_POP;
    return OP_IDLE;
  endfunction

  function automatic byte_t sp_after(byte_t sp, stk_op_e op, byte_t ld_val);
    case (op)
      OP_LOAD:   return ld_val;
      OP_LINK:   return sp - byte_t'(2);
      OP_UNLINK: return sp + byte_t'(2);
      OP_PUSH:   return sp - byte_t'(1);
      OP_POP:    return sp + byte_t'(1);
      default:   return sp;
    endcase
  endfunction

  function automatic logic ram_present(logic seg_zero, byte_t off, int top);
    return seg_zero && (int'(off) <= top);
  endfunction

  function automatic byte_t ram_fill(logic present, byte_t raw);
    return present ? raw : byte_t'(8'hFF);
  endfunction

endpackage

// File: rtl/trap_sp.sv
`timescale 1ns/1ps
module trap_sp
  import trap_pkg::*;
#(
  parameter int SP_RST = 8'h6F
) (
  input  logic    clk,
  input  logic    rst_n,
  input  stk_op_e op,
  input  byte_t   ld_val,
  output byte_t   sp
);

  byte_t sp_nxt;
  assign sp_nxt = sp_after(sp, op, ld_val);

  always_ff @(posedge clk) begin
    if (!rst_n) sp <= byte_t'(SP_RST);
    else        sp <= sp_nxt;
  end

  // R3
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_PUSH |=> sp == $past(sp) - byte_t'(1));
  // R3
  swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SWAP |=> $stable(sp));
  // R2
  link_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LINK |=> sp == $past(sp) - byte_t'(2));
  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOAD |=> sp == $past(ld_val));

endmodule

// File: rtl/trap_stack_mem.sv
`timescale 1ns/1ps
module trap_stack_mem
  import trap_pkg::*;
#(
  parameter int TOP   = 8'h6F,
  parameter int SEG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op,
  input  byte_t            sp,
  input  byte_t            link_lo,
  input  byte_t            link_hi,
  input  byte_t            push_data,
  input  logic [SEG_W-1:0] rd_seg,
  input  byte_t            rd_off,
  output byte_t            rd_data,
  output byte_t            above1,
  output byte_t            above2
);

  localparam int DEPTH = TOP + 1;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  byte_t cells [DEPTH];

  // Two write ports: port A at SP, port B at SP-1 (link only)
  logic  we_a, we_b;
  byte_t wa_a, wa_b, wd_a, wd_b;

  always_comb begin
    wa_a = sp;
    wa_b = sp - byte_t'(1);
    wd_a = (op == OP_LINK) ? link_lo : push_data;
    wd_b = link_hi;
    we_a = ((op == OP_LINK) || (op == OP_PUSH)) && ram_present(1'b1, wa_a, TOP);
    we_b = (op == OP_LINK) && ram_present(1'b1, wa_b, TOP);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    byte_t q;
    always_ff @(posedge clk) begin
      if (!rst_n)                         q <= '0;
      else if (we_a && wa_a == byte_t'(g)) q <= wd_a;
      else if (we_b && wa_b == byte_t'(g)) q <= wd_b;
    end
    assign cells[g] = q;
  end

  function automatic byte_t seg0_read(byte_t off);
    logic ok;
    ok = ram_present(1'b1, off, TOP);
    return ram_fill(ok, ok ? cells[off[IDX_W-1:0]] : byte_t'(0));
  endfunction

  logic  rd_present;
  byte_t rd_raw;
  assign rd_present = ram_present(rd_seg == '0, rd_off, TOP);
  assign rd_raw     = rd_present ? cells[rd_off[IDX_W-1:0]] : byte_t'(0);
  assign rd_data    = ram_fill(rd_present, rd_raw);
  assign above1     = seg0_read(sp + byte_t'(1));
  assign above2     = seg0_read(sp + byte_t'(2));

  // R5
  fill_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_present |-> rd_data == 8'hFF);
  // R5
  no_ghost_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_a |-> int'(wa_a) <= TOP);

endmodule

// File: rtl/trap_fetch_guard.sv
`timescale 1ns/1ps
module trap_fetch_guard
  import trap_pkg::*;
#(
  parameter int PC_W    = 15,
  parameter int ROM_TOP = 12'hFFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch,
  input  logic [PC_W-1:0] addr,
  input  byte_t           rom_raw,
  input  logic            clr,
  output byte_t           data,
  output logic            pend
);

  localparam byte_t SWI_OPC = 8'h00;

  logic rom_present;
  logic trap_evt;

  assign rom_present = addr <= PC_W'(ROM_TOP);
  assign data        = rom_present ? rom_raw : SWI_OPC;
  assign trap_evt    = fetch && (data == SWI_OPC);

  always_ff @(posedge clk) begin
    if (!rst_n)        pend <= 1'b0;
    else if (trap_evt) pend <= 1'b1;
    else if (clr)      pend <= 1'b0;
  end

  // R6
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > PC_W'(ROM_TOP)) |-> data == 8'h00);
  // R7
  trap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_evt |=> pend);
  // R7
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !clr |=> pend);
  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !trap_evt |=> !pend);

endmodule

// File: rtl/illegal_trap_unit.sv
`timescale 1ns/1ps
module illegal_trap_unit
  import trap_pkg::*;
#(
  parameter int PC_W    = 15,
  parameter int ROM_TOP = 12'hFFF,
  parameter int RAM_TOP = 8'h6F,
  parameter int SEG_W   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   call_i,
  input  logic                   irq_i,
  input  logic                   ret_i,
  input  logic                   push_i,
  input  logic                   pop_i,
  input  logic [PC_W-1:0]        link_pc_i,
  input  logic [7:0]             push_data_i,
  input  logic                   sp_load_i,
  input  logic [7:0]             sp_load_val_i,
  input  logic [SEG_W+7:0]       ram_rd_addr_i,
  output logic [7:0]             ram_rd_data_o,
  input  logic                   fetch_i,
  input  logic [PC_W-1:0]        fetch_addr_i,
  input  logic [7:0]             rom_data_i,
  output logic [7:0]             fetch_data_o,
  input  logic                   clr_pend_i,
  output logic [7:0]             sp_o,
  output logic [PC_W-1:0]        ret_addr_o,
  output logic [7:0]             pop_data_o,
  output logic                   swi_pend_o,
  output logic                   underflow_o
);

  stk_op_e op;
  byte_t   sp;
  byte_t   above1, above2;
  byte_t   link_lo, link_hi;
  logic [PC_W-1:0] ret_join;

  assign op      = decode_op(sp_load_i, call_i || irq_i, ret_i, push_i, pop_i);
  assign link_lo = link_pc_i[7:0];
  assign link_hi = byte_t'(link_pc_i >> 8);
  // Byte above SP is the high half, next one is the low half
  assign ret_join = PC_W'({above1, above2});

  trap_sp #(.SP_RST(RAM_TOP)) u_sp (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .ld_val (sp_load_val_i),
    .sp     (sp)
  );

  trap_stack_mem #(.TOP(RAM_TOP), .SEG_W(SEG_W)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .sp        (sp),
    .link_lo   (link_lo),
    .link_hi   (link_hi),
    .push_data (push_data_i),
    .rd_seg    (ram_rd_addr_i[SEG_W+7:8]),
    .rd_off    (ram_rd_addr_i[7:0]),
    .rd_data   (ram_rd_data_o),
    .above1    (above1),
    .above2    (above2)
  );

  trap_fetch_guard #(.PC_W(PC_W), .ROM_TOP(ROM_TOP)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .fetch   (fetch_i),
    .addr    (fetch_addr_i),
    .rom_raw (rom_data_i),
    .clr     (clr_pend_i),
    .data    (fetch_data_o),
    .pend    (swi_pend_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_addr_o <= '0;
      pop_data_o <= '0;
    end else begin
      if (op == OP_UNLINK) ret_addr_o <= ret_join;
      if (op == OP_POP)    pop_data_o <= above1;
      if (op == OP_SWAP)   pop_data_o <= push_data_i;
    end
  end

  assign sp_o        = sp;
  assign underflow_o = int'(sp) > RAM_TOP;

  // R8
  load_freezes_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOAD |=> $stable(ret_addr_o) && $stable(pop_data_o));
  // R4
  unlink_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_UNLINK |=> sp_o == $past(sp_o) + 8'd2);
  // R11
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_UNLINK && int'(sp_o) == RAM_TOP |=> &ret_addr_o);

endmodule

// File: tb/illegal_trap_unit_bench.sv
`timescale 1ns/1ps
module illegal_trap_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        call_i, irq_i, ret_i, push_i, pop_i, sp_load_i, fetch_i, clr_pend_i;
  logic [14:0] link_pc_i, fetch_addr_i;
  logic [7:0]  push_data_i, sp_load_val_i, rom_data_i;
  logic [9:0]  ram_rd_addr_i;
  logic [7:0]  ram_rd_data_o, fetch_data_o, sp_o, pop_data_o;
  logic [14:0] ret_addr_o;
  logic        swi_pend_o, underflow_o;

  always #10 clk = ~clk;

  illegal_trap_unit u_illegal_trap_unit (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state
  logic [7:0]  m_mem [0:111];
  logic [7:0]  m_sp, m_pop;
  logic [14:0] m_ret;
  logic        m_pend;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_rd(input logic [1:0] seg, input logic [7:0] off);
    if (seg == 2'd0 && off <= 8'h6F) return m_mem[off];
    return 8'hFF;
  endfunction

  function automatic logic [7:0] exp_fetch(input logic [14:0] a, input logic [7:0] raw);
    return (a <= 15'hFFF) ? raw : 8'h00;
  endfunction

  task automatic check_regs(input string tag);
    chk({tag, " sp"}, sp_o, m_sp);
    chk("R10 underflow", underflow_o, (m_sp > 8'h6F));
    chk("R4 ret_addr", ret_addr_o, m_ret);
    chk("R3 pop_data", pop_data_o, m_pop);
    chk("R7 pending", swi_pend_o, m_pend);
  endtask

  // Called just after a falling edge
  task automatic step(input logic c, input logic iq, input logic r, input logic pu,
                      input logic po, input logic ld, input logic [7:0] ldv,
                      input logic [14:0] pc, input logic [7:0] pd, input logic f,
                      input logic [14:0] fa, input logic [7:0] rom, input logic cl,
                      input logic [9:0] ra);
    string tag;
    logic [7:0] s1, fd;
    call_i = c; irq_i = iq; ret_i = r; push_i = pu; pop_i = po;
    sp_load_i = ld; sp_load_val_i = ldv; link_pc_i = pc; push_data_i = pd;
    fetch_i = f; fetch_addr_i = fa; rom_data_i = rom; clr_pend_i = cl; ram_rd_addr_i = ra;
    #1;
    fd = exp_fetch(fa, rom);
    chk("R6 fetch_data", fetch_data_o, fd);
    chk("R5 ram_rd_data", ram_rd_data_o, m_rd(ra[9:8], ra[7:0]));
    @(posedge clk);
    tag = ((c || iq) && (r || pu || po)) || (r && (pu || po)) ? "R9" : "R3";
    if (ld) begin
      tag = "R8"; m_sp = ldv;
    end else if (c || iq) begin
      if (tag != "R9") tag = "R2";
      if (m_sp <= 8'h6F) m_mem[m_sp] = pc[7:0];
      s1 = m_sp - 8'd1;
      if (s1 <= 8'h6F) m_mem[s1] = 8'(pc >> 8);
      m_sp = m_sp - 8'd2;
    end else if (r) begin
      if (tag != "R9") tag = "R4";
      m_ret = 15'({m_rd(2'd0, m_sp + 8'd1), m_rd(2'd0, m_sp + 8'd2)});
      m_sp = m_sp + 8'd2;
    end else if (pu && po) begin
      m_pop = pd;
    end else if (pu) begin
      if (m_sp <= 8'h6F) m_mem[m_sp] = pd;
      m_sp = m_sp - 8'd1;
    end else if (po) begin
      m_pop = m_rd(2'd0, m_sp + 8'd1);
      m_sp = m_sp + 8'd1;
    end
    if (f && fd == 8'h00) m_pend = 1'b1;
    else if (cl)          m_pend = 1'b0;
    @(negedge clk);
    check_regs(tag);
  endtask

  task automatic idle_read(input logic [9:0] ra);
    step(0,0,0,0,0,0,8'h0,15'h0,8'h0,0,15'h0,8'h11,0,ra);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int r;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 112; i++) m_mem[i] = 8'h00;
    m_sp = 8'h6F; m_pop = 8'h00; m_ret = 15'h0; m_pend = 1'b0;
    {call_i, irq_i, ret_i, push_i, pop_i, sp_load_i, fetch_i, clr_pend_i} = '0;
    link_pc_i = '0; fetch_addr_i = '0; push_data_i = '0; sp_load_val_i = '0;
    rom_data_i = '0; ram_rd_addr_i = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_regs("R1");
    idle_read(10'h06F);
    chk("R1 stored byte cleared", ram_rd_data_o, 8'h00);

    // R2 call then R4 return round trip
    step(1,0,0,0,0,0,8'h0,15'h1234,8'h0,0,15'h0,8'h5,0,10'h06F);
    chk("R2 sp after call", sp_o, 8'h6D);
    idle_read(10'h06F);
    chk("R2 low byte at SP", ram_rd_data_o, 8'h34);
    idle_read(10'h06E);
    chk("R2 high byte at SP-1", ram_rd_data_o, 8'h12);
    step(0,0,1,0,0,0,8'h0,15'h0,8'h0,0,15'h0,8'h5,0,10'h000);
    chk("R4 return address", ret_addr_o, 15'h1234);
    // R11 over-return
    step(0,0,1,0,0,0,8'h0,15'h0,8'h0,0,15'h0,8'h5,0,10'h070);
    chk("R11 overrun return address", ret_addr_o, 15'h7FFF);
    chk("R11 underflow", underflow_o, 1);
    step(0,0,0,0,0,0,8'h0,15'h0,8'h0,1,15'h7FFF,8'hAB,0,10'h170);
    chk("R11 pending after fetch", swi_pend_o, 1);
    // R7 set wins over clear
    step(0,0,0,0,0,0,8'h0,15'h0,8'h0,1,15'h0800,8'h00,1,10'h000);
    chk("R7 set beats clear", swi_pend_o, 1);
    step(0,0,0,0,0,0,8'h0,15'h0,8'h0,1,15'h1000,8'h7,1,10'h000);
    chk("R7 first unpopulated fetch", swi_pend_o, 1);
    step(0,0,0,0,0,0,8'h0,15'h0,8'h0,1,15'h0FFF,8'h7,1,10'h000);
    chk("R7 clear", swi_pend_o, 0);
    // R8 load with competing call
    step(1,0,0,1,0,1,8'h6F,15'h2222,8'h9,0,15'h0,8'h1,0,10'h000);
    chk("R8 load wins", sp_o, 8'h6F);
    // R3 push/pop pair
    step(0,0,0,1,1,0,8'h0,15'h0,8'hC3,0,15'h0,8'h1,0,10'h000);
    chk("R3 swap data", pop_data_o, 8'hC3);
    chk("R3 swap sp", sp_o, 8'h6F);

    for (int n = 0; n < 4000; n++) begin
      logic c, iq, rt, pu, po, ld, f, cl;
      logic [7:0] ldv, rom;
      logic [14:0] fa;
      logic [9:0] ra;
      {c, iq, rt, pu, po, ld} = '0;
      r = $urandom % 100;
      if (r < 4)       ld = 1;
      else if (r < 14) c = 1;
      else if (r < 17) iq = 1;
      else if (r < 28) rt = 1;
      else if (r < 41) pu = 1;
      else if (r < 53) po = 1;
      else if (r < 58) {pu, po} = 2'b11;
      else if (r < 63) {c, rt, pu} = 3'b111;
      else if (r < 66) {rt, po} = 2'b11;
      else if (r < 69) {ld, c} = 2'b11;
      case ($urandom % 4)
        0: ldv = 8'h6F;
        1: ldv = 8'h6D;
        default: ldv = 8'(8'h60 + ($urandom % 22));
      endcase
      case ($urandom % 10)
        0, 1, 2:    fa = 15'(12'h000 + ($urandom % 4096));
        3, 4:       fa = 15'(15'h1000 + ($urandom % 28672));
        5:          fa = 15'h7FFF;
        6:          fa = 15'h1000;
        7:          fa = 15'h0FFF;
        default:    fa = 15'($urandom);
      endcase
      rom = ($urandom % 5 == 0) ? 8'h00 : 8'($urandom);
      f   = $urandom % 2 == 0;
      cl  = $urandom % 8 == 0;
      ra  = ($urandom % 2 == 0) ? {2'b00, 8'($urandom)} : 10'($urandom);
      step(c, iq, rt, pu, po, ld, ldv, 15'($urandom), 8'($urandom), f, fa, rom, cl, ra);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule